// File: doc/BRIEF.md
# Boot-Mode Selector and Address Decoder

This block fixes the operating mode of the chip at the moment reset is released and then decodes every bus address against that mode. On the first rising clock edge after `rst_n` goes high, it samples a 3-bit environment code from the board straps together with a flash-empty indication. It turns the pair into one of five modes and holds that mode until the next reset.

With the latched mode, a purely combinational decoder takes a 24-bit byte address. It returns a one-hot region select and a flag that says whether the access goes to the external bus. A reserved-access flag is raised for any address outside the populated map, and also for an address that the current mode does not support. The block only steers accesses. It contains no memory, no wait-state logic and no flash programming logic. Its outputs are plain level signals with no handshake.

Top module: `boot_map_decoder`

## Requirements
- R1: The mode is captured on the first rising `clk` edge with `rst_n` high, and `mode_valid` rises on that edge. While `rst_n` is low, `mode` reads 3 (development) and `mode_valid` reads 0. After capture, changes on `env_pins` or `flash_empty` leave `mode` unchanged until the next reset.
- R2: Environment code 3'b111 gives internal-execution mode (code 0) when `flash_empty` is 0. It gives program-load mode (code 2) when `flash_empty` is 1.
- R3: Environment code 3'b011 gives external-execution mode (code 1) when `flash_empty` is 0. It gives program-load mode (code 2) when `flash_empty` is 1.
- R4: Environment code 3'b110 gives program-load mode (code 2) whatever the value of `flash_empty`.
- R5: Environment code 3'b100 gives development-internal mode (code 4). Every other code (000, 001, 010, 101) gives development mode (code 3). `flash_empty` has no effect on either.
- R6: `region_sel` always has exactly one bit set. The bits and the inclusive address ranges they decode are:
  - bit 0: program flash, 000000h–03FFFFh
  - bit 1: data flash, 0D0000h–0D1FFFh
  - bit 2: system RAM, 0E8000h–0E91FFh
  - bit 3: radio data RAM, 0EE800h–0EEBFFh
  - bit 4: sequencer RAM, 0EEC00h–0EEFFFh
  - bit 5: CAN buffers, 0EF000h–0EF13Fh
  - bit 6: link registers, 0EF180h–0EF1FFh
  - bit 7: external zone 1, 100000h–3FFFFFh
  - bit 8: external zone 2, 400000h–7FFFFFh
  - bit 9: peripherals, FF0000h–FFF1FFh and FFFC00h–FFFFFFh
  - bit 10: system I/O, FFF600h–FFFBFFh
  - bit 11: reserved
- R7: Any address outside the ranges of R6 selects bit 11, sets `reserved_err` to 1 and sets `is_external` to 0.
- R8: In modes 0 and 2, external memory is not supported. Addresses in the external zones select bit 11 and set `reserved_err`. All other mapped regions are internal.
- R9: In mode 1, the two external zones have `is_external` set to 1. All on-chip regions are internal.
- R10: In mode 3, program flash, data flash, the static zone 0 regions (bits 2 to 6) and both external zones have `is_external` set to 1.
- R11: In mode 4, program flash, data flash and both external zones are external. The static zone 0 regions (bits 2 to 6) stay internal.
- R12: The peripheral and system I/O regions are internal in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_pins | input | 3 | Environment strap code, sampled once after reset |
| flash_empty | input | 1 | High when program flash is unprogrammed |
| addr | input | 24 | Byte address to decode |
| mode | output | 3 | Latched mode code (0..4) |
| mode_valid | output | 1 | High once the mode has been captured |
| region_sel | output | 12 | One-hot region select |
| is_external | output | 1 | Access is routed to the external bus |
| reserved_err | output | 1 | Access hits a reserved or unsupported range |

## Verification
The bench probes the first and last byte of each region and the byte just past it, such as 03FFFFh against 040000h and 0EF13Fh against 0EF140h. A decoder with an off-by-one compare would report the wrong region there, or miss the reserved flag. Each environment code is exercised with both values of `flash_empty`. A selector that ignored the empty status, or let it override code 110, would latch the wrong mode. After capture, the straps are moved to a different code, so a design that kept sampling would change its mode. The same static zone 0 and flash addresses are decoded in both development variants, which exposes a router that mixes up which regions move to the external bus.

// File: rtl/bm_pkg.sv
package bm_pkg;

  localparam int ADDR_W   = 24;
  localparam int ENV_W    = 3;
  localparam int MODE_W   = 3;
  localparam int N_REGION = 12;
  localparam int N_RANGE  = 12;

  typedef enum logic [MODE_W-1:0] {
    MD_INT_EXEC  = 3'd0,
    MD_EXT_EXEC  = 3'd1,
    MD_PROG_LOAD = 3'd2,
    MD_DEVELOP   = 3'd3,
    MD_DEV_INT   = 3'd4
  } bm_mode_e;

  // region bit positions
  localparam int RG_PFLASH = 0;
  localparam int RG_DFLASH = 1;
  localparam int RG_SYSRAM = 2;
  localparam int RG_RADIO  = 3;
  localparam int RG_SEQ    = 4;
  localparam int RG_CAN    = 5;
  localparam int RG_LINK   = 6;
  localparam int RG_EXT1   = 7;
  localparam int RG_EXT2   = 8;
  localparam int RG_PERIPH = 9;
  localparam int RG_SYSIO  = 10;
  localparam int RG_RESV   = 11;

  localparam int ZONE0_LO  = RG_SYSRAM;
  localparam int ZONE0_HI  = RG_LINK;

  // Inclusive bounds of each populated range
  function automatic logic [ADDR_W-1:0] range_lo(input int idx);
    case (idx)
      0:       range_lo = 24'h000000;
      1:       range_lo = 24'h0D0000;
      2:       range_lo = 24'h0E8000;
      3:       range_lo = 24'h0EE800;
      4:       range_lo = 24'h0EEC00;
      5:       range_lo = 24'h0EF000;
      6:       range_lo = 24'h0EF180;
      7:       range_lo = 24'h100000;
      8:       range_lo = 24'h400000;
      9:       range_lo = 24'hFF0000;
      10:      range_lo = 24'hFFF600;
      default: range_lo = 24'hFFFC00;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] range_hi(input int idx);
    case (idx)
      0:       range_hi = 24'h03FFFF;
      1:       range_hi = 24'h0D1FFF;
      2:       range_hi = 24'h0E91FF;
      3:       range_hi = 24'h0EEBFF;
      4:       range_hi = 24'h0EEFFF;
      5:       range_hi = 24'h0EF13F;
      6:       range_hi = 24'h0EF1FF;
      7:       range_hi = 24'h3FFFFF;
      8:       range_hi = 24'h7FFFFF;
      9:       range_hi = 24'hFFF1FF;
      10:      range_hi = 24'hFFFBFF;
      default: range_hi = 24'hFFFFFF;
    endcase
  endfunction

  // Which region bit each range reports into
  function automatic int range_region(input int idx);
    if (idx == N_RANGE - 1) range_region = RG_PERIPH;
    else                    range_region = idx;
  endfunction

  function automatic bm_mode_e env_to_mode(input logic [ENV_W-1:0] env,
                                           input logic empty);
    case (env)
      3'b111:  env_to_mode = empty ? MD_PROG_LOAD : MD_INT_EXEC;
      3'b011:  env_to_mode = empty ? MD_PROG_LOAD : MD_EXT_EXEC;
      3'b110:  env_to_mode = MD_PROG_LOAD;
      3'b100:  env_to_mode = MD_DEV_INT;
      default: env_to_mode = MD_DEVELOP;
    endcase
  endfunction

endpackage

// File: rtl/bm_mode_latch.sv
module bm_mode_latch
  import bm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ENV_W-1:0] env_pins,
  input  logic             flash_empty,
  output bm_mode_e         mode,
  output logic             locked
);

  bm_mode_e mode_q;
  logic     locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_DEVELOP;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      mode_q   <= env_to_mode(env_pins, flash_empty);
      locked_q <= 1'b1;
    end
  end

  assign mode   = mode_q;
  assign locked = locked_q;

endmodule

// File: rtl/bm_region_decode.sv
module bm_region_decode
  import bm_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  output logic [N_REGION-1:0] raw_hit
);

  logic [N_RANGE-1:0] range_hit;

  for (genvar g = 0; g < N_RANGE; g++) begin : g_range
    localparam logic [ADDR_W-1:0] LO = range_lo(g);
    localparam logic [ADDR_W-1:0] HI = range_hi(g);
    if (LO == '0) begin : g_zero_base
      assign range_hit[g] = (addr <= HI);
    end else if (HI == '1) begin : g_top_end
      assign range_hit[g] = (addr >= LO);
    end else begin : g_mid
      assign range_hit[g] = (addr >= LO) && (addr <= HI);
    end
  end

  always_comb begin
    raw_hit = '0;
    for (int r = 0; r < N_RANGE; r++) begin
      if (range_hit[r]) raw_hit[range_region(r)] = 1'b1;
    end
  end

endmodule

// File: rtl/bm_route.sv
module bm_route
  import bm_pkg::*;
(
  input  bm_mode_e            mode,
  input  logic [N_REGION-1:0] raw_hit,
  output logic [N_REGION-1:0] region_sel,
  output logic                is_external,
  output logic                reserved_err
);

  logic is_flash;
  logic is_zone0;
  logic is_xzone;
  logic unmapped;

  assign is_flash = raw_hit[RG_PFLASH] | raw_hit[RG_DFLASH];
  assign is_zone0 = |raw_hit[ZONE0_HI:ZONE0_LO];
  assign is_xzone = raw_hit[RG_EXT1] | raw_hit[RG_EXT2];
  assign unmapped = (raw_hit == '0);

  always_comb begin
    region_sel  = raw_hit;
    is_external = 1'b0;
    unique case (mode)
      MD_INT_EXEC, MD_PROG_LOAD: begin
        if (is_xzone) region_sel = '0;
      end
      MD_EXT_EXEC: is_external = is_xzone;
      MD_DEV_INT:  is_external = is_flash | is_xzone;
      default:     is_external = is_flash | is_zone0 | is_xzone;
    endcase
    if (unmapped || region_sel == '0) begin
      region_sel          = '0;
      region_sel[RG_RESV] = 1'b1;
      is_external         = 1'b0;
    end
  end

  assign reserved_err = region_sel[RG_RESV];

endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
  import bm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ENV_W-1:0]    env_pins,
  input  logic                flash_empty,
  input  logic [ADDR_W-1:0]   addr,
  output logic [MODE_W-1:0]   mode,
  output logic                mode_valid,
  output logic [N_REGION-1:0] region_sel,
  output logic                is_external,
  output logic                reserved_err
);

  bm_mode_e            cur_mode;
  logic [N_REGION-1:0] raw_hit;

  bm_mode_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .env_pins   (env_pins),
    .flash_empty(flash_empty),
    .mode       (cur_mode),
    .locked     (mode_valid)
  );

  bm_region_decode u_decode (
    .addr   (addr),
    .raw_hit(raw_hit)
  );

  bm_route u_route (
    .mode        (cur_mode),
    .raw_hit     (raw_hit),
    .region_sel  (region_sel),
    .is_external (is_external),
    .reserved_err(reserved_err)
  );

  assign mode = cur_mode;

endmodule

// File: rtl/bm_checker.sv
module bm_checker
  import bm_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic [MODE_W-1:0]   mode,
  input logic                mode_valid,
  input logic [N_REGION-1:0] region_sel,
  input logic                is_external,
  input logic                reserved_err
);

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && $past(mode_valid)) |-> $stable(mode)) else $error("mode moved"); // R1

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_valid) |-> mode_valid) else $error("mode_valid fell"); // R1

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(region_sel) == 1) else $error("region select not one-hot"); // R6

  AST_RESV_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_err |-> !is_external) else $error("reserved routed out"); // R7

  AST_NO_XMEM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && (mode == MD_INT_EXEC || mode == MD_PROG_LOAD) &&
     addr >= 24'h100000 && addr <= 24'h7FFFFF) |-> reserved_err)
    else $error("external zone allowed"); // R8

  AST_DEV_FLASH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MD_DEVELOP || mode == MD_DEV_INT) && addr <= 24'h03FFFF) |-> is_external)
    else $error("flash not external in development"); // R10

  AST_IO_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 24'hFF0000) |-> !is_external) else $error("I/O routed out"); // R12

endmodule

bind boot_map_decoder bm_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .mode        (mode),
  .mode_valid  (mode_valid),
  .region_sel  (region_sel),
  .is_external (is_external),
  .reserved_err(reserved_err)
);

// File: tb/tb_boot_map_decoder.sv
module tb_boot_map_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  env_pins = 3'b111;
  logic        flash_empty = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  mode;
  logic        mode_valid;
  logic [11:0] region_sel;
  logic        is_external;
  logic        reserved_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boot_map_decoder dut (
    .clk(clk), .rst_n(rst_n), .env_pins(env_pins), .flash_empty(flash_empty),
    .addr(addr), .mode(mode), .mode_valid(mode_valid), .region_sel(region_sel),
    .is_external(is_external), .reserved_err(reserved_err)
  );

  // {env, empty, addr, sel, ext, err, mode}
  localparam int NV = 29;
  localparam logic [44:0] VEC [NV] = '{
    {3'b111,1'b0,24'h000000,12'h001,1'b0,1'b0,3'd0},
    {3'b111,1'b0,24'h03FFFF,12'h001,1'b0,1'b0,3'd0},
    {3'b111,1'b0,24'h040000,12'h800,1'b0,1'b1,3'd0},
    {3'b111,1'b0,24'h0D1FFF,12'h002,1'b0,1'b0,3'd0},
    {3'b111,1'b0,24'h100000,12'h800,1'b0,1'b1,3'd0},
    {3'b111,1'b0,24'hFFF1FF,12'h200,1'b0,1'b0,3'd0},
    {3'b111,1'b0,24'hFFF200,12'h800,1'b0,1'b1,3'd0},
    {3'b111,1'b0,24'hFFFB00,12'h400,1'b0,1'b0,3'd0},
    {3'b111,1'b0,24'hFFFFFF,12'h200,1'b0,1'b0,3'd0},
    {3'b011,1'b0,24'h100000,12'h080,1'b1,1'b0,3'd1},
    {3'b011,1'b0,24'h7FFFFF,12'h100,1'b1,1'b0,3'd1},
    {3'b011,1'b0,24'h800000,12'h800,1'b0,1'b1,3'd1},
    {3'b011,1'b0,24'h000100,12'h001,1'b0,1'b0,3'd1},
    {3'b111,1'b1,24'h400000,12'h800,1'b0,1'b1,3'd2},
    {3'b111,1'b1,24'h0E8000,12'h004,1'b0,1'b0,3'd2},
    {3'b110,1'b0,24'h0EF13F,12'h020,1'b0,1'b0,3'd2},
    {3'b110,1'b0,24'h0EF140,12'h800,1'b0,1'b1,3'd2},
    {3'b000,1'b0,24'h000000,12'h001,1'b1,1'b0,3'd3},
    {3'b000,1'b0,24'h0E91FF,12'h004,1'b1,1'b0,3'd3},
    {3'b000,1'b0,24'h0EF180,12'h040,1'b1,1'b0,3'd3},
    {3'b000,1'b0,24'h0D0000,12'h002,1'b1,1'b0,3'd3},
    {3'b000,1'b0,24'hFF0000,12'h200,1'b0,1'b0,3'd3},
    {3'b000,1'b0,24'h200000,12'h080,1'b1,1'b0,3'd3},
    {3'b100,1'b1,24'h03FFFF,12'h001,1'b1,1'b0,3'd4},
    {3'b100,1'b1,24'h0EE800,12'h008,1'b0,1'b0,3'd4},
    {3'b100,1'b1,24'h0EEC00,12'h010,1'b0,1'b0,3'd4},
    {3'b100,1'b1,24'h0E9200,12'h800,1'b0,1'b1,3'd4},
    {3'b101,1'b1,24'h0EEFFF,12'h010,1'b1,1'b0,3'd3},
    {3'b011,1'b1,24'h600000,12'h800,1'b0,1'b1,3'd2}
  };

  function automatic string mode_tag(input logic [2:0] env);
    case (env)
      3'b111:  return "R2";
      3'b011:  return "R3";
      3'b110:  return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string route_tag(input logic [2:0] m, input logic err,
                                      input logic [23:0] a);
    if (a >= 24'hFF0000) return "R12";
    if (err) return "R7";
    case (m)
      3'd1:    return "R9";
      3'd3:    return "R10";
      3'd4:    return "R11";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reset with straps applied, release, wait past the capture edge
  task automatic boot(input logic [2:0] env, input logic emp);
    @(negedge clk);
    rst_n = 1'b0;
    env_pins = env;
    flash_empty = emp;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]  v_env, v_mode;
    logic        v_emp, v_ext, v_err;
    logic [23:0] v_addr;
    logic [11:0] v_sel;

    // reset state (R1)
    repeat (2) @(negedge clk);
    check("R1", "mode_valid in reset", {31'b0, mode_valid}, 32'd0);
    check("R1", "mode in reset", {29'b0, mode}, 32'd3);

    // vector table
    for (int i = 0; i < NV; i++) begin
      {v_env, v_emp, v_addr, v_sel, v_ext, v_err, v_mode} = VEC[i];
      if (i == 0 || v_env != env_pins || v_emp != flash_empty || !rst_n) begin
        boot(v_env, v_emp);
        check(mode_tag(v_env), "latched mode", {29'b0, mode}, {29'b0, v_mode});
        check("R1", "mode_valid after release", {31'b0, mode_valid}, 32'd1);
      end
      addr = v_addr;
      #2;
      check("R6", "region_sel", {20'b0, region_sel}, {20'b0, v_sel});
      check(route_tag(v_mode, v_err, v_addr), "is_external",
            {31'b0, is_external}, {31'b0, v_ext});
      check(route_tag(v_mode, v_err, v_addr), "reserved_err",
            {31'b0, reserved_err}, {31'b0, v_err});
      @(negedge clk);
    end

    // R1: straps moved after capture are ignored
    boot(3'b011, 1'b0);
    env_pins = 3'b110;
    flash_empty = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "mode held after strap change", {29'b0, mode}, 32'd1);
    addr = 24'h300000;
    #2;
    check("R9", "ext zone still external", {31'b0, is_external}, 32'd1);

    // R1: in reset the mode is development and straps are not captured
    @(negedge clk);
    rst_n = 1'b0;
    env_pins = 3'b111;
    #2;
    check("R1", "mode back to reset value", {29'b0, mode}, 32'd3);
    check("R1", "mode_valid cleared", {31'b0, mode_valid}, 32'd0);
    repeat (3) @(negedge clk);
    check("R1", "no capture while in reset", {31'b0, mode_valid}, 32'd0);

    // R4 with empty flag low is covered above; with it high here
    boot(3'b110, 1'b1);
    check("R4", "program-load ignores empty", {29'b0, mode}, 32'd2);

    // R5: remaining codes map to development
    boot(3'b001, 1'b0);
    check("R5", "code 001", {29'b0, mode}, 32'd3);
    boot(3'b010, 1'b1);
    check("R5", "code 010", {29'b0, mode}, 32'd3);
    boot(3'b100, 1'b0);
    check("R5", "code 100 empty low", {29'b0, mode}, 32'd4);

    // R11: static zone 0 internal, data flash external
    addr = 24'h0EF000;
    #2;
    check("R11", "CAN internal", {31'b0, is_external}, 32'd0);
    addr = 24'h0D1000;
    #2;
    check("R11", "data flash external", {31'b0, is_external}, 32'd1);
    addr = 24'h0EF17F;
    #2;
    check("R7", "gap before link regs", {20'b0, region_sel}, 32'h800);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule